// File: doc/BRIEF.md
# Synchronous Burst Address Generator

This block supplies the word address that a synchronous burst SRAM presents to its array each cycle. On a rising clock edge it can take a fresh external address from either of two burst-start strobes. One strobe comes from the processor side and the other from the controller side. Both are qualified by chip enable. Once an address is loaded, the low bits come from a small beat counter. The counter moves forward only on cycles where the advance input is high. The upper bits stay fixed for the whole burst.

A static mode input picks how the beat count folds into the low address bits. In linear order the beat count is added to the loaded low bits. In interleaved order it is XORed with them. The counter is two bits wide by default, which gives four beats. It wraps back to the first beat and never carries into the upper bits. Bursting is optional: a new address may be loaded on every cycle, and it reaches the output after the same single edge as any other update.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst` is high at a rising edge, `addr_out` becomes 0 and the beat count becomes 0.
- R2: At an edge where `ce` is 1 and either `proc_stb` or `ctrl_stb` is 1, `addr_out` after that edge equals `addr_in`, and the beat count restarts at 0.
- R3: At an edge where `ce` is 0, both strobes have no effect. The output behaves exactly as if both strobes were 0: it holds, or it steps if `adv` is 1.
- R4: At an edge with no load and `adv` = 1, the beat count goes up by one, modulo 2^BEAT_W.
- R5: At an edge with no load and `adv` = 0, `addr_out` keeps its value.
- R6: When `order_xor` = 0 (linear), the low BEAT_W bits of `addr_out` equal (loaded low bits + beat count) mod 2^BEAT_W.
- R7: When `order_xor` = 1 (interleaved), the low BEAT_W bits of `addr_out` equal the loaded low bits XOR the beat count.
- R8: Bits above BEAT_W never change except on a load. After 2^BEAT_W advances the output is back at the loaded address.
- R9: A load takes priority over `adv`. With both strobes high on the same edge, exactly one load of `addr_in` happens and the beat count is 0.
- R10: Loads on consecutive edges each appear on `addr_out` one edge later, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Chip enable; qualifies both strobes |
| proc_stb | input | 1 | Processor-side burst-start strobe |
| ctrl_stb | input | 1 | Controller-side burst-start strobe |
| adv | input | 1 | Step the beat counter |
| order_xor | input | 1 | 0 = linear order, 1 = interleaved order |
| addr_in | input | ADDR_W | External address captured on a load |
| addr_out | output | ADDR_W | Registered internal address |

## Verification
The assertions assume that every input is a known 0 or 1 at each sampled edge. They also assume that `order_xor` is held steady across a burst. A change of order in the middle of a burst remaps the low bits, although it never touches the upper bits. The bench changes the mode only on cycles that also load a new address. It sweeps every starting low value in both orders through more than a full wrap. It then runs a random mix of enable, strobe and advance patterns, and its model recomputes the expected address arithmetically.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } order_e;
endpackage

// File: rtl/bag_strobe_qual.sv
module bag_strobe_qual (
  input  logic ce,
  input  logic proc_stb,
  input  logic ctrl_stb,
  output logic load
);
  logic proc_ok;
  logic ctrl_ok;

  always_comb begin
    proc_ok = proc_stb & ce;
    ctrl_ok = ctrl_stb & ce;
    load    = proc_ok | ctrl_ok;
  end
endmodule

// File: rtl/bag_beat_counter.sv
module bag_beat_counter #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              adv,
  output logic [BEAT_W-1:0] beat_next,
  output logic [BEAT_W-1:0] beat_q
);
  localparam logic [BEAT_W-1:0] ONE = BEAT_W'(1);

  always_comb begin
    if (load)     beat_next = '0;
    else if (adv) beat_next = beat_q + ONE;
    else          beat_next = beat_q;
  end

  always_ff @(posedge clk) begin
    if (rst) beat_q <= '0;
    else     beat_q <= beat_next;
  end

  assert_step_R4: assert property (@(posedge clk) disable iff (rst)
    (!load && adv) |=> (beat_q == $past(beat_q) + ONE));
  assert_restart_R9: assert property (@(posedge clk) disable iff (rst)
    load |=> (beat_q == '0));
endmodule

// File: rtl/bag_addr_map.sv
module bag_addr_map
  import burst_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  order_e            order,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [BEAT_W-1:0] beat_next,
  output logic [ADDR_W-1:0] addr_out
);
  localparam int UP_W = ADDR_W - BEAT_W;

  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] base_next;
  logic [BEAT_W-1:0] low_next;

  always_comb begin
    base_next = load ? addr_in : base_q;
    if (order == ORD_XOR) low_next = base_next[BEAT_W-1:0] ^ beat_next;
    else                  low_next = base_next[BEAT_W-1:0] + beat_next;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q   <= '0;
      addr_out <= '0;
    end else begin
      base_q   <= base_next;
      addr_out <= {base_next[ADDR_W-1:BEAT_W], low_next};
    end
  end

  assert_upper_fixed_R8: assert property (@(posedge clk) disable iff (rst)
    !load |=> (addr_out[ADDR_W-1:BEAT_W] == $past(addr_out[ADDR_W-1:BEAT_W])));

  initial begin
    assert_width_ok_R8: assert (UP_W >= 1);
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              proc_stb,
  input  logic              ctrl_stb,
  input  logic              adv,
  input  logic              order_xor,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out
);
  logic              load;
  logic [BEAT_W-1:0] beat_next;
  logic [BEAT_W-1:0] beat_q;
  order_e            order;

  assign order = order_e'(order_xor);

  bag_strobe_qual u_qual (
    .ce       (ce),
    .proc_stb (proc_stb),
    .ctrl_stb (ctrl_stb),
    .load     (load)
  );

  bag_beat_counter #(.BEAT_W(BEAT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .adv       (adv),
    .beat_next (beat_next),
    .beat_q    (beat_q)
  );

  bag_addr_map #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_map (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .order     (order),
    .addr_in   (addr_in),
    .beat_next (beat_next),
    .addr_out  (addr_out)
  );

  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    (ce && (proc_stb || ctrl_stb)) |=> (addr_out == $past(addr_in)));
  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!(ce && (proc_stb || ctrl_stb)) && !adv) |=> $stable(addr_out));
  assert_gate_R3: assert property (@(posedge clk) disable iff (rst)
    (!ce && !adv) |=> $stable(addr_out));
endmodule

// File: tb/sim_burst_addr_gen.sv
module sim_burst_addr_gen;
  localparam int AW = 10;
  localparam int BW = 2;
  localparam int NB = 1 << BW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ce = 1'b0, proc_stb = 1'b0, ctrl_stb = 1'b0, adv = 1'b0, order_xor = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out;

  int n_chk = 0;
  int n_bad = 0;
  logic [AW-1:0] m_base = '0;
  int            m_beat = 0;
  logic [AW-1:0] m_exp  = '0;

  burst_addr_gen #(.ADDR_W(AW), .BEAT_W(BW)) u0 (
    .clk(clk), .rst(rst), .ce(ce), .proc_stb(proc_stb), .ctrl_stb(ctrl_stb),
    .adv(adv), .order_xor(order_xor), .addr_in(addr_in), .addr_out(addr_out)
  );

  always #10 clk = ~clk;

  function automatic logic [AW-1:0] model_addr(logic [AW-1:0] b, int bt, logic ox);
    int lo;
    if (ox) lo = int'(b[BW-1:0]) ^ bt;
    else    lo = (int'(b[BW-1:0]) + bt) % NB;
    return {b[AW-1:BW], BW'(lo)};
  endfunction

  task automatic check(string tag);
    n_chk++;
    if (addr_out !== m_exp) begin
      n_bad++;
      $display("FAIL %s: addr_out=%h expected=%h", tag, addr_out, m_exp);
    end
  endtask

  task automatic step(logic c, logic p, logic k, logic a, logic ox,
                      logic [AW-1:0] ai, string tag);
    ce = c; proc_stb = p; ctrl_stb = k; adv = a; order_xor = ox; addr_in = ai;
    @(posedge clk);
    if (c && (p || k)) begin
      m_base = ai; m_beat = 0;
    end else if (a) begin
      m_beat = (m_beat + 1) % NB;
    end
    m_exp = model_addr(m_base, m_beat, ox);
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: addr_out=%h expected=finish", addr_out);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    m_exp = '0;
    check("R1");
    rst = 1'b0;

    for (int ox = 0; ox < 2; ox++) begin
      for (int s = 0; s < NB; s++) begin
        logic [AW-1:0] a0;
        a0 = AW'((s * 37 + ox * 200) << BW) | AW'(s);
        step(1, 1, 0, 0, ox[0], a0, "R2");
        step(1, 0, 0, 0, ox[0], ~a0, "R5");
        for (int b = 0; b < NB + 1; b++)
          step(1, 0, 0, 1, ox[0], ~a0, ox[0] ? "R7" : "R6");
        step(0, 0, 0, 1, ox[0], ~a0, "R8");
      end
    end

    step(1, 0, 1, 0, 1'b0, 10'h155, "R2");
    step(0, 1, 1, 0, 1'b0, 10'h2aa, "R3");
    step(0, 1, 0, 1, 1'b0, 10'h2aa, "R3");
    step(0, 0, 1, 1, 1'b0, 10'h2aa, "R3");
    step(1, 1, 1, 1, 1'b1, 10'h0c2, "R9");
    step(1, 0, 1, 1, 1'b1, 10'h0c3, "R9");
    step(1, 0, 0, 1, 1'b1, 10'h000, "R4");

    for (int i = 0; i < 8; i++)
      step(1, i[0], ~i[0], 1, 1'b0, AW'(i * 71 + 5), "R10");

    for (int i = 0; i < 400; i++) begin
      logic [3:0] r;
      logic       ox;
      r  = 4'($urandom);
      ox = order_xor;
      if (r[0] & (r[1] | r[2])) ox = 1'($urandom);
      step(r[0], r[1], r[2], r[3], ox, AW'($urandom), "R4");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule